// File: doc/BRIEF.md
# Debug-Bus Status Polling Sequencer

This block sits above a byte-level serial transceiver on an on-chip debug link. It produces the byte sequences that poll a target's status until a condition holds. It runs two operations.

The first operation is a control/status poll. It sends one command byte, made by ORing a load-control/status opcode with a status-register index, and it receives one reply byte. It repeats this until the non-volatile-memory enable bit of the reply is set, or until a bounded number of tries is used up.

The second operation is a controller poll. It sends a direct-load opcode whose data-size field asks for one byte, then a 32-bit address as four bytes, and then it receives one reply byte. It repeats this until bit 7 of the reply (the controller busy flag) is clear.

When either operation ends, the block raises a one-cycle done pulse and a success flag. The success flag stays valid until the next operation finishes.

The state machine has four states:
- `ST_IDLE` waits for a start strobe.
- `ST_SEND` offers bytes to the transceiver.
- `ST_RECV` waits for the reply byte.
- `ST_DONE` emits the done pulse.

The transitions are:
- start: `ST_IDLE` to `ST_SEND`.
- byte accepted, more bytes to send: `ST_SEND` to `ST_SEND`.
- last byte accepted: `ST_SEND` to `ST_RECV`.
- retry, condition not met and tries remain: `ST_RECV` to `ST_SEND`.
- finish, condition met or tries used up: `ST_RECV` to `ST_DONE`.
- release: `ST_DONE` to `ST_IDLE`.

Top module: `stpoll_seq`

## Requirements
- R1: After reset, `done_o`, `busy_o`, `tx_valid_o` and `rx_en_o` are low and `ok_o` is low.
- R2: Each control/status poll attempt sends exactly one byte, equal to `LDCS_OP | STATUS_IDX` (0x80 by default), and then waits for one reply.
- R3: The control/status poll finishes with `ok_o` = 1 on the first reply whose bit `NVM_EN_BIT` (bit 1 by default) is 1. No other reply bit affects the result.
- R4: The control/status poll makes at most `CSR_TRIES` attempts (255 by default). If all of them fail, it finishes with `ok_o` = 0 and sends no further command. A success on the last allowed attempt still gives `ok_o` = 1.
- R5: Each controller poll attempt starts with the byte `LDS_OP` with bits 3:2 forced to 00, the one-byte data-size code. With the default this byte is 0x03.
- R6: After the opcode, the controller poll sends the address `DATA_BASE | CTRL_BASE | CTRL_OFS` as four bytes, most significant byte first. With the defaults these bytes are 0x01, 0x00, 0x01, 0xCF.
- R7: The controller poll repeats while reply bit 7 is 1 and finishes with `ok_o` = 1 when bit 7 is 0. With `CTRL_TRIES` = 0 (the default) it has no attempt limit. A nonzero value bounds it like R4.
- R8: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_valid_o` stays high and `tx_byte_o` does not change.
- R9: The block holds `rx_en_o` high and makes no progress until `rx_valid_i` arrives. It never offers a byte while it waits for a reply.
- R10: A start strobe is ignored while an operation is active. If both strobes arrive together while idle, the control/status poll runs.
- R11: `done_o` is high for exactly one cycle per operation. `ok_o` changes only in a cycle in which `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_csr_i | input | 1 | Strobe that starts the control/status poll |
| start_ctrl_i | input | 1 | Strobe that starts the controller busy poll |
| tx_byte_o | output | 8 | Byte offered to the transceiver |
| tx_valid_o | output | 1 | `tx_byte_o` is valid |
| tx_ready_i | input | 1 | Transceiver takes the byte this cycle |
| rx_en_o | output | 1 | The block waits for a reply byte |
| rx_byte_i | input | 8 | Reply byte from the transceiver |
| rx_valid_i | input | 1 | One-cycle pulse: `rx_byte_i` is valid |
| busy_o | output | 1 | An operation is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ok_o | output | 1 | Result of the last operation: 1 success, 0 timeout |

## Verification
Control/status replies are tried in three forms:
- All bits set except the enable bit. This shows the block looks only at bit 1.
- Runs of failures that end on the first, fourth and 255th attempt. These separate a correct bound from off-by-one bounds.
- An unbroken run of 255 failures. This exposes a missing timeout or a 256th command.

Controller replies are tried in two forms:
- 0x80 as busy and 0x7F as clear. This shows only bit 7 decides the result.
- A busy run longer than 255 attempts. This shows the controller poll carries no hidden bound.

Stalled ready and late reply pulses check that the block holds its byte and waits. Simultaneous and mid-operation strobes check that a busy start is ignored and that the control/status poll wins a tie.

// File: rtl/stpoll_pkg.sv
package stpoll_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_RECV,
        ST_DONE
    } stpoll_state_e;

    typedef enum logic {
        OP_CSR,
        OP_CTRL
    } stpoll_op_e;

    localparam int unsigned IDX_W = 3;
endpackage

// File: rtl/stpoll_cmd_gen.sv
module stpoll_cmd_gen
    import stpoll_pkg::*;
#(
    parameter logic [7:0]  LDCS_OP    = 8'h80,
    parameter logic [7:0]  STATUS_IDX = 8'h00,
    parameter logic [7:0]  LDS_OP     = 8'h03,
    parameter logic [31:0] DATA_BASE  = 32'h0100_0000,
    parameter logic [31:0] CTRL_BASE  = 32'h0000_01C0,
    parameter logic [31:0] CTRL_OFS   = 32'h0000_000F
) (
    input  stpoll_op_e       op_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [7:0]       byte_o,
    output logic [IDX_W-1:0] last_idx_o
);
    localparam logic [1:0]  SIZE_ONE  = 2'd0;
    localparam logic [7:0]  CSR_CMD   = LDCS_OP | STATUS_IDX;
    localparam logic [7:0]  LDS_CMD   = (LDS_OP & 8'hF3) | {4'b0, SIZE_ONE, 2'b00};
    localparam logic [31:0] POLL_ADDR = DATA_BASE | CTRL_BASE | CTRL_OFS;
    localparam int unsigned ADDR_BYTES = 4;

    logic [7:0] addr_bytes [ADDR_BYTES];

    // Address bytes in send order: entry 0 carries the most significant byte
    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_addr
        assign addr_bytes[g] = POLL_ADDR[8*(ADDR_BYTES-1-g) +: 8];
    end

    always_comb begin
        if (op_i == OP_CSR) begin
            byte_o     = CSR_CMD;
            last_idx_o = '0;
        end else begin
            last_idx_o = IDX_W'(ADDR_BYTES);
            if (idx_i == '0 || idx_i > IDX_W'(ADDR_BYTES)) byte_o = LDS_CMD;
            else                                           byte_o = addr_bytes[idx_i - 1'b1];
        end
    end
endmodule

// File: rtl/stpoll_tries.sv
module stpoll_tries #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             bump_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             last_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr_i)  cnt_q <= '0;
        else if (bump_i) cnt_q <= cnt_q + 1'b1;
    end

    // A zero limit means unbounded
    assign last_o = (limit_i != '0) && (cnt_q == limit_i - 1'b1);
endmodule

// File: rtl/stpoll_seq.sv
module stpoll_seq
    import stpoll_pkg::*;
#(
    parameter logic [7:0]  LDCS_OP    = 8'h80,
    parameter logic [7:0]  STATUS_IDX = 8'h00,
    parameter logic [7:0]  LDS_OP     = 8'h03,
    parameter logic [31:0] DATA_BASE  = 32'h0100_0000,
    parameter logic [31:0] CTRL_BASE  = 32'h0000_01C0,
    parameter logic [31:0] CTRL_OFS   = 32'h0000_000F,
    parameter int unsigned NVM_EN_BIT = 1,
    parameter int unsigned CSR_TRIES  = 255,
    parameter int unsigned CTRL_TRIES = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_csr_i,
    input  logic       start_ctrl_i,
    output logic [7:0] tx_byte_o,
    output logic       tx_valid_o,
    input  logic       tx_ready_i,
    output logic       rx_en_o,
    input  logic [7:0] rx_byte_i,
    input  logic       rx_valid_i,
    output logic       busy_o,
    output logic       done_o,
    output logic       ok_o
);
    localparam int unsigned MAX_TRIES = (CSR_TRIES > CTRL_TRIES) ? CSR_TRIES : CTRL_TRIES;
    localparam int unsigned CNT_W     = $clog2(MAX_TRIES + 1) + 1;
    localparam int unsigned EN_BIT    = NVM_EN_BIT % 8;

    stpoll_state_e    state_q, state_d;
    stpoll_op_e       op_q;
    logic [IDX_W-1:0] idx_q;
    logic             ok_q;
    logic [IDX_W-1:0] last_idx;
    logic             last_try;
    logic             cond_met;
    logic [CNT_W-1:0] limit;
    logic             start_any;
    logic             byte_take;
    logic             reply_in;

    stpoll_cmd_gen #(
        .LDCS_OP   (LDCS_OP),
        .STATUS_IDX(STATUS_IDX),
        .LDS_OP    (LDS_OP),
        .DATA_BASE (DATA_BASE),
        .CTRL_BASE (CTRL_BASE),
        .CTRL_OFS  (CTRL_OFS)
    ) u_cmd (
        .op_i      (op_q),
        .idx_i     (idx_q),
        .byte_o    (tx_byte_o),
        .last_idx_o(last_idx)
    );

    assign limit = (op_q == OP_CSR) ? CNT_W'(CSR_TRIES) : CNT_W'(CTRL_TRIES);

    assign start_any = (state_q == ST_IDLE) && (start_csr_i || start_ctrl_i);
    assign byte_take = (state_q == ST_SEND) && tx_ready_i;
    assign reply_in  = (state_q == ST_RECV) && rx_valid_i;
    assign cond_met  = (op_q == OP_CSR) ? rx_byte_i[EN_BIT] : !rx_byte_i[7];

    stpoll_tries #(.CNT_W(CNT_W)) u_tries (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (start_any),
        .bump_i (reply_in && !cond_met),
        .limit_i(limit),
        .last_o (last_try)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_csr_i || start_ctrl_i) state_d = ST_SEND;
            ST_SEND: if (tx_ready_i && idx_q == last_idx) state_d = ST_RECV;
            ST_RECV: if (rx_valid_i) state_d = (cond_met || last_try) ? ST_DONE : ST_SEND;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q  <= OP_CSR;
            idx_q <= '0;
            ok_q  <= 1'b0;
        end else begin
            if (start_any) begin
                op_q  <= start_csr_i ? OP_CSR : OP_CTRL;
                idx_q <= '0;
            end
            if (byte_take) idx_q <= (idx_q == last_idx) ? '0 : idx_q + 1'b1;
            if (reply_in && (cond_met || last_try)) ok_q <= cond_met;
        end
    end

    always_comb begin
        tx_valid_o = 1'b0;
        rx_en_o    = 1'b0;
        done_o     = 1'b0;
        busy_o     = 1'b1;
        unique case (state_q)
            ST_IDLE: busy_o     = 1'b0;
            ST_SEND: tx_valid_o = 1'b1;
            ST_RECV: rx_en_o    = 1'b1;
            ST_DONE: done_o     = 1'b1;
            default: busy_o     = 1'b0;
        endcase
    end

    assign ok_o = ok_q;
endmodule

// File: rtl/stpoll_seq_chk.sv
module stpoll_seq_chk #(
    parameter logic [7:0] LDCS_OP    = 8'h80,
    parameter logic [7:0] STATUS_IDX = 8'h00
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start_csr_i,
    input logic [7:0] tx_byte_o,
    input logic       tx_valid_o,
    input logic       tx_ready_i,
    input logic       rx_en_o,
    input logic       rx_valid_i,
    input logic       busy_o,
    input logic       done_o,
    input logic       ok_o
);
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_ok_moves_with_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ok_o) |-> done_o);

    assert_tx_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_byte_o)));

    assert_rx_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_en_o && !rx_valid_i) |=> rx_en_o);

    assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_valid_o && rx_en_o));

    assert_csr_first_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_csr_i && !busy_o) |=> (tx_valid_o && tx_byte_o == (LDCS_OP | STATUS_IDX)));

    assert_stay_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);
endmodule

bind stpoll_seq stpoll_seq_chk #(
    .LDCS_OP   (LDCS_OP),
    .STATUS_IDX(STATUS_IDX)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_csr_i(start_csr_i),
    .tx_byte_o  (tx_byte_o),
    .tx_valid_o (tx_valid_o),
    .tx_ready_i (tx_ready_i),
    .rx_en_o    (rx_en_o),
    .rx_valid_i (rx_valid_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .ok_o       (ok_o)
);

// File: tb/stpoll_seq_tb.sv
module stpoll_seq_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_csr_i = 1'b0;
    logic       start_ctrl_i = 1'b0;
    logic [7:0] tx_byte_o;
    logic       tx_valid_o;
    logic       tx_ready_i = 1'b0;
    logic       rx_en_o;
    logic [7:0] rx_byte_i = 8'h00;
    logic       rx_valid_i = 1'b0;
    logic       busy_o;
    logic       done_o;
    logic       ok_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #5 clk = ~clk;

    stpoll_seq dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_csr_i (start_csr_i),
        .start_ctrl_i(start_ctrl_i),
        .tx_byte_o   (tx_byte_o),
        .tx_valid_o  (tx_valid_o),
        .tx_ready_i  (tx_ready_i),
        .rx_en_o     (rx_en_o),
        .rx_byte_i   (rx_byte_i),
        .rx_valid_i  (rx_valid_i),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .ok_o        (ok_o)
    );

    task automatic check(input logic cond, input string req, input int act, input int exp);
        n_tests++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Waits for an offered byte, compares it, optionally stalls ready, then accepts it
    task automatic expect_tx(input logic [7:0] exp, input string req, input int stall);
        int w = 0;
        while (!tx_valid_o && w < 40) begin
            @(negedge clk);
            w++;
        end
        check(tx_valid_o == 1'b1, {req, " byte offered"}, tx_valid_o, 1);
        check(tx_byte_o == exp, req, tx_byte_o, exp);
        for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            check(tx_valid_o && tx_byte_o == exp, "R8 byte held while not ready", tx_byte_o, exp);
        end
        tx_ready_i = 1'b1;
        @(negedge clk);
        tx_ready_i = 1'b0;
    endtask

    // Waits for the reply request, optionally delays, then pulses the reply
    task automatic give_rx(input logic [7:0] b, input int stall);
        int w = 0;
        while (!rx_en_o && w < 40) begin
            @(negedge clk);
            w++;
        end
        check(rx_en_o == 1'b1, "R9 reply requested", rx_en_o, 1);
        for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            check(rx_en_o && !tx_valid_o && !done_o, "R9 waits for reply", {rx_en_o, tx_valid_o, done_o}, 3'b100);
        end
        rx_byte_i  = b;
        rx_valid_i = 1'b1;
        @(negedge clk);
        rx_valid_i = 1'b0;
    endtask

    task automatic wait_done(input logic exp_ok, input string req);
        int w = 0;
        while (!done_o && w < 20) begin
            @(negedge clk);
            w++;
        end
        check(done_o == 1'b1, {req, " done seen"}, done_o, 1);
        check(ok_o == exp_ok, req, ok_o, exp_ok);
        @(negedge clk);
        check(done_o == 1'b0, "R11 done lasts one cycle", done_o, 0);
        check(ok_o == exp_ok, "R11 ok held after done", ok_o, exp_ok);
        check(busy_o == 1'b0, "R11 idle after done", busy_o, 0);
    endtask

    task automatic pulse_start(input logic csr, input logic ctrl);
        start_csr_i  = csr;
        start_ctrl_i = ctrl;
        @(negedge clk);
        start_csr_i  = 1'b0;
        start_ctrl_i = 1'b0;
    endtask

    task automatic csr_iter(input logic [7:0] reply);
        expect_tx(8'h80, "R2 csr command byte", 0);
        give_rx(reply, 0);
    endtask

    task automatic ctrl_iter(input logic [7:0] reply);
        expect_tx(8'h03, "R5 direct-load opcode", 0);
        expect_tx(8'h01, "R6 address byte 3", 0);
        expect_tx(8'h00, "R6 address byte 2", 0);
        expect_tx(8'h01, "R6 address byte 1", 0);
        expect_tx(8'hCF, "R6 address byte 0", 0);
        give_rx(reply, 0);
    endtask

    task automatic t_reset();
        check(!done_o && !busy_o && !tx_valid_o && !rx_en_o && !ok_o, "R1 reset outputs",
              {done_o, busy_o, tx_valid_o, rx_en_o, ok_o}, 0);
    endtask

    task automatic t_csr_first();
        pulse_start(1'b1, 1'b0);
        csr_iter(8'h02);
        wait_done(1'b1, "R3 csr success on first reply");
    endtask

    task automatic t_csr_retry();
        pulse_start(1'b1, 1'b0);
        for (int i = 0; i < 3; i++) csr_iter(8'hFD);
        csr_iter(8'h02);
        wait_done(1'b1, "R3 csr success after three misses");
    endtask

    task automatic t_csr_timeout();
        pulse_start(1'b1, 1'b0);
        for (int i = 0; i < 255; i++) csr_iter(8'hFD);
        check(tx_valid_o == 1'b0, "R4 no 256th command", tx_valid_o, 0);
        wait_done(1'b0, "R4 csr timeout after 255 attempts");
    endtask

    task automatic t_csr_last();
        pulse_start(1'b1, 1'b0);
        for (int i = 0; i < 254; i++) csr_iter(8'hFD);
        csr_iter(8'h02);
        wait_done(1'b1, "R4 success on 255th attempt");
    endtask

    task automatic t_ctrl_short();
        pulse_start(1'b0, 1'b1);
        ctrl_iter(8'h80);
        ctrl_iter(8'h80);
        ctrl_iter(8'h7F);
        wait_done(1'b1, "R7 controller poll ends when bit 7 clear");
    endtask

    task automatic t_ctrl_long();
        pulse_start(1'b0, 1'b1);
        for (int i = 0; i < 260; i++) ctrl_iter(8'hFF);
        ctrl_iter(8'h00);
        wait_done(1'b1, "R7 no attempt limit on controller poll");
    endtask

    task automatic t_ignore_busy();
        pulse_start(1'b0, 1'b1);
        pulse_start(1'b1, 1'b0);
        ctrl_iter(8'h80);
        pulse_start(1'b1, 1'b1);
        ctrl_iter(8'h00);
        wait_done(1'b1, "R10 busy start ignored");
    endtask

    task automatic t_priority();
        pulse_start(1'b1, 1'b1);
        expect_tx(8'h80, "R10 csr wins simultaneous start", 0);
        give_rx(8'h02, 0);
        wait_done(1'b1, "R10 csr poll completes");
    endtask

    task automatic t_stall();
        pulse_start(1'b0, 1'b1);
        expect_tx(8'h03, "R8 opcode under stall", 3);
        expect_tx(8'h01, "R8 address byte under stall", 2);
        expect_tx(8'h00, "R6 address byte 2", 0);
        expect_tx(8'h01, "R6 address byte 1", 0);
        expect_tx(8'hCF, "R8 last byte under stall", 4);
        give_rx(8'h00, 5);
        wait_done(1'b1, "R9 completes after late reply");
    endtask

    initial begin
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_csr_first();
        t_csr_retry();
        t_csr_timeout();
        t_csr_last();
        t_ctrl_short();
        t_ctrl_long();
        t_ignore_busy();
        t_priority();
        t_stall();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule